// File: doc/BRIEF.md
# Buffered JTAG Vector Shift Master

This block drives a four-wire JTAG port from a memory-mapped register bank. A host stages up to 128 bits of mode-select pattern and up to 128 bits of outgoing scan data as four 32-bit words each. It programs a burst length and a clock divider, then writes a go bit. The block then generates the test clock, presents one mode-select bit and one data bit per clock period, and records the bit returned by the target on each rising clock edge in a 128-bit capture buffer.

When the last bit has been shifted, the block stops the test clock low, clears its busy flag and raises an interrupt. The host reads the capture words and acknowledges. A longer scan is split into several bursts. The test clock simply rests between them for as long as the host takes, so no timing is guaranteed between bursts.

Register map (word addresses): 0–3 mode-select words, 4–7 outgoing data words, 8–11 capture words (read only), 12 length, 13 divider, 14 control. Within each 128-bit vector, bit k sits in word k/32 at bit position k mod 32, and bit 0 is shifted first.

Top module: `jvm_top`

## Requirements
- R1: After synchronous reset the test clock is low, the mode-select pin is high, the data-out pin is low, irq is low, and every register (addresses 0–14) reads 0.
- R2: A burst produces exactly length+1 test-clock pulses, where length is bits 6:0 of address 12 (1 to 128 pulses). Each half period of the clock is divider+1 system clocks, where divider is bits 15:0 of address 13. Rising edges are therefore 2·(divider+1) system clocks apart.
- R3: At the k-th rising edge of a burst (k counted from 0), the mode-select pin carries bit k of the mode-select vector and the data-out pin carries bit k of the outgoing vector. Both pins change only while the test clock is low, and never while it is high.
- R4: The data-in pin is sampled on the k-th rising edge into bit k of the capture vector (addresses 8–11). A go clears the capture vector, so bits at or beyond the burst length read 0.
- R5: At the end of a burst the busy flag (address 14, read bit 0) clears and irq (address 14, read bit 1, and the irq pin) rises. The test clock rests low, and the mode-select and data-out pins hold the last shifted bit.
- R6: While busy, every bus write is ignored. This covers the buffers, the length, the divider and the go bit, so a second go neither restarts nor lengthens the burst.
- R7: irq stays high until the host writes bit 1 of address 14 (acknowledge) or starts the next burst by writing bit 0 (go).
- R8: Addresses 0–7, 12 and 13 read back the value last written (length 7 bits, divider 16 bits). Writes to the capture words are ignored, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | 4 | Word address of the register bus |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from regAddr |
| irq | output | 1 | Burst-complete interrupt, level |
| jtagTck | output | 1 | Test clock |
| jtagTms | output | 1 | Mode-select output |
| jtagTdo | output | 1 | Scan data to the target |
| jtagTdi | input | 1 | Scan data returned by the target |

## Verification
Some properties are checked by assertions on every cycle. The test clock rests low whenever no burst runs, and busy and irq are never high together. Every fall of busy comes with irq. The shift index never passes the programmed length, and the length and divider cannot move mid-burst. The mode-select and data-out pins hold still while the test clock is high. Other behaviour needs the bench's scenarios to show it: bit order and pulse count at the extremes of length 1 and 128, the rising-edge spacing for several dividers, the capture contents and their clearing, the pins holding after a burst, and writes being dropped during a burst.

// File: rtl/jvm_pkg.sv
package jvm_pkg;
  // Register banks selected by the two address bits above the word select
  localparam logic [1:0] BANK_TMS  = 2'd0;
  localparam logic [1:0] BANK_DATA = 2'd1;
  localparam logic [1:0] BANK_CAP  = 2'd2;
  localparam logic [1:0] BANK_CFG  = 2'd3;
  // Word offsets inside the configuration bank
  localparam logic [1:0] CFG_LEN   = 2'd0;
  localparam logic [1:0] CFG_DIV   = 2'd1;
  localparam logic [1:0] CFG_CTRL  = 2'd2;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;     // burst accepted: clear capture, present bit 0
    logic sample;   // rising test-clock edge: capture data-in
    logic advance;  // falling test-clock edge: present next bit
  } jvm_stb_t;
endpackage

// File: rtl/jvm_ctrl.sv
module jvm_ctrl
  import jvm_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int DIV_W = 16,
  localparam int BITS   = WORDS * DW,
  localparam int CNT_W  = $clog2(BITS),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int ADDR_W = WSEL_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DIV_W-1:0]  cfgWrData,
  output logic [DW-1:0]     cfgRdData,
  output logic              busy,
  output logic              irq,
  output logic              tck,
  output logic [CNT_W-1:0]  bitIdx,
  output jvm_stb_t          stb
);
  logic [CNT_W-1:0] lenM1;
  logic [DIV_W-1:0] divider;
  logic [DIV_W-1:0] halfCnt;
  logic             cfgSel;
  logic [WSEL_W-1:0] wsel;
  logic             halfDone;
  logic             goReq;

  assign wsel     = regAddr[WSEL_W-1:0];
  assign cfgSel   = regAddr[ADDR_W-1:WSEL_W] == BANK_CFG;
  assign halfDone = busy && (halfCnt == divider);
  assign goReq    = regWrEn && !busy && cfgSel && wsel == WSEL_W'(CFG_CTRL) && cfgWrData[0];

  assign stb.load    = goReq;
  assign stb.sample  = halfDone && !tck;
  assign stb.advance = halfDone && tck && (bitIdx != lenM1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      irq     <= 1'b0;
      tck     <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
      lenM1   <= '0;
      divider <= '0;
    end else if (!busy) begin
      if (regWrEn && cfgSel) begin
        if (wsel == WSEL_W'(CFG_LEN)) lenM1 <= cfgWrData[CNT_W-1:0];
        if (wsel == WSEL_W'(CFG_DIV)) divider <= cfgWrData;
        if (wsel == WSEL_W'(CFG_CTRL)) begin
          if (cfgWrData[0]) begin
            busy    <= 1'b1;
            irq     <= 1'b0;
            tck     <= 1'b0;
            halfCnt <= '0;
            bitIdx  <= '0;
          end else if (cfgWrData[1]) begin
            irq <= 1'b0;
          end
        end
      end
    end else if (halfDone) begin
      halfCnt <= '0;
      tck     <= ~tck;
      if (tck) begin
        if (bitIdx == lenM1) begin
          busy <= 1'b0;
          irq  <= 1'b1;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgSel) begin
      if (wsel == WSEL_W'(CFG_LEN))  cfgRdData = DW'(lenM1);
      if (wsel == WSEL_W'(CFG_DIV))  cfgRdData = DW'(divider);
      if (wsel == WSEL_W'(CFG_CTRL)) cfgRdData = DW'({irq, busy});
    end
  end

  // R5: the test clock rests low outside a burst
  a_r5_tck_rest_low: assert property (@(posedge clk) disable iff (rst) !busy |-> !tck);
  // R5: busy and irq are exclusive
  a_r5_irq_busy_excl: assert property (@(posedge clk) disable iff (rst) !(busy && irq));
  // R5: every burst end raises irq
  a_r5_done_irq: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> irq);
  // R2: the shift index never passes the programmed length
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (rst) busy |-> bitIdx <= lenM1);
  // R6: configuration is frozen during a burst
  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(lenM1) && $stable(divider)));
endmodule

// File: rtl/jvm_datapath.sv
module jvm_datapath
  import jvm_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int BITS   = WORDS * DW,
  localparam int CNT_W  = $clog2(BITS),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int ADDR_W = WSEL_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     bufRdData,
  input  logic              busy,
  input  logic              tck,
  input  logic [CNT_W-1:0]  bitIdx,
  input  jvm_stb_t          stb,
  input  logic              jtagTdi,
  output logic              jtagTms,
  output logic              jtagTdo
);
  logic [BITS-1:0]   tmsVec;
  logic [BITS-1:0]   outVec;
  logic [BITS-1:0]   capVec;
  logic [1:0]        bank;
  logic [WSEL_W-1:0] wsel;
  logic [CNT_W-1:0]  nextIdx;
  logic              wrOk;

  assign bank    = regAddr[ADDR_W-1:WSEL_W];
  assign wsel    = regAddr[WSEL_W-1:0];
  assign nextIdx = bitIdx + 1'b1;
  assign wrOk    = regWrEn && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmsVec <= '0;
      outVec <= '0;
    end else if (wrOk) begin
      for (int w = 0; w < WORDS; w++) begin
        if (wsel == WSEL_W'(w)) begin
          if (bank == BANK_TMS)  tmsVec[w*DW +: DW] <= regWrData;
          if (bank == BANK_DATA) outVec[w*DW +: DW] <= regWrData;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capVec  <= '0;
      jtagTms <= 1'b1;
      jtagTdo <= 1'b0;
    end else if (stb.load) begin
      capVec  <= '0;
      jtagTms <= tmsVec[0];
      jtagTdo <= outVec[0];
    end else begin
      if (stb.sample) capVec[bitIdx] <= jtagTdi;
      if (stb.advance) begin
        jtagTms <= tmsVec[nextIdx];
        jtagTdo <= outVec[nextIdx];
      end
    end
  end

  always_comb begin
    bufRdData = '0;
    case (bank)
      BANK_TMS:  bufRdData = tmsVec[wsel*DW +: DW];
      BANK_DATA: bufRdData = outVec[wsel*DW +: DW];
      BANK_CAP:  bufRdData = capVec[wsel*DW +: DW];
      default:   bufRdData = '0;
    endcase
  end

  // R3: scan pins hold while the test clock is high
  a_r3_pins_hold_high: assert property (@(posedge clk) disable iff (rst)
    (tck && $past(tck)) |-> ($stable(jtagTms) && $stable(jtagTdo)));
  // R6: buffers do not move during a burst
  a_r6_buffers_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(tmsVec) && $stable(outVec)));
endmodule

// File: rtl/jvm_top.sv
module jvm_top
  import jvm_pkg::*;
#(
  parameter int WORDS = 4,   // power of two, at least 4
  parameter int DW    = 32,
  parameter int DIV_W = 16,
  localparam int BITS   = WORDS * DW,
  localparam int CNT_W  = $clog2(BITS),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int ADDR_W = WSEL_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  output logic              irq,
  output logic              jtagTck,
  output logic              jtagTms,
  output logic              jtagTdo,
  input  logic              jtagTdi
);
  jvm_stb_t         stb;
  logic             busy;
  logic [CNT_W-1:0] bitIdx;
  logic [DW-1:0]    bufRd;
  logic [DW-1:0]    cfgRd;

  jvm_ctrl #(.WORDS(WORDS), .DW(DW), .DIV_W(DIV_W)) ctrlInst (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .cfgWrData(regWrData[DIV_W-1:0]), .cfgRdData(cfgRd),
    .busy(busy), .irq(irq), .tck(jtagTck), .bitIdx(bitIdx), .stb(stb)
  );

  jvm_datapath #(.WORDS(WORDS), .DW(DW)) dpInst (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .bufRdData(bufRd), .busy(busy), .tck(jtagTck),
    .bitIdx(bitIdx), .stb(stb), .jtagTdi(jtagTdi),
    .jtagTms(jtagTms), .jtagTdo(jtagTdo)
  );

  assign regRdData = (regAddr[ADDR_W-1:WSEL_W] == BANK_CFG) ? cfgRd : bufRd;
endmodule

// File: tb/jvm_top_test.sv
module jvm_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq, jtagTck, jtagTms, jtagTdo;
  logic        jtagTdi = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  jvm_top uut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .jtagTck(jtagTck), .jtagTms(jtagTms), .jtagTdo(jtagTdo), .jtagTdi(jtagTdi)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic runBurst(input int len, input int div, input logic [127:0] tv,
                          input logic [127:0] dv, input logic [127:0] iv, input bit meddle);
    logic [31:0]  r;
    logic [127:0] mask;
    int k, cyc, lastRise;
    bit prev;
    for (int w = 0; w < 4; w++) begin
      wr(4'(w), tv[w*32 +: 32]);
      wr(4'(4 + w), dv[w*32 +: 32]);
    end
    wr(4'd12, 32'(len - 1));
    wr(4'd13, 32'(div));
    jtagTdi = iv[0];
    wr(4'd14, 32'h1);
    chk(irq == 1'b0, "R7 go clears irq", 128'(irq), 128'd0);
    k = 0; cyc = 0; lastRise = 0; prev = 1'b0;
    while (!irq && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (jtagTck && !prev) begin
        chk(k < 128 && jtagTms == tv[k], "R3 tms bit", 128'(jtagTms), 128'(tv[k]));
        chk(k < 128 && jtagTdo == dv[k], "R3 tdo bit", 128'(jtagTdo), 128'(dv[k]));
        if (k > 0 && !meddle)
          chk(cyc - lastRise == 2 * (div + 1), "R2 rise spacing", 128'(cyc - lastRise), 128'(2 * (div + 1)));
        lastRise = cyc;
        k++;
        if (meddle && k == 1) begin
          wr(4'd0, ~tv[31:0]);   // R6 buffer write during burst
          wr(4'd12, 32'd0);      // R6 length write during burst
          wr(4'd14, 32'h1);      // R6 go during burst
        end
      end else if (!jtagTck && prev && !irq) begin
        jtagTdi = iv[k];
      end
      prev = jtagTck;
    end
    chk(irq == 1'b1, "R5 irq at end", 128'(irq), 128'd1);
    chk(k == len, "R2 pulse count", 128'(k), 128'(len));
    chk(jtagTck == 1'b0, "R5 tck rests low", 128'(jtagTck), 128'd0);
    chk(jtagTms == tv[len-1] && jtagTdo == dv[len-1], "R5 pins hold last bit",
        128'({jtagTms, jtagTdo}), 128'({tv[len-1], dv[len-1]}));
    repeat (5) @(negedge clk);
    chk(jtagTms == tv[len-1], "R5 tms still held", 128'(jtagTms), 128'(tv[len-1]));
    rd(4'd14, r);
    chk(r == 32'h2, "R5 status idle with irq", 128'(r), 128'h2);
    mask = (len == 128) ? '1 : ((128'd1 << len) - 128'd1);
    for (int w = 0; w < 4; w++) begin
      rd(4'(8 + w), r);
      chk(r == (iv & mask) >> (w * 32) & 32'hFFFF_FFFF ? 1'b1 : r == 32'((iv & mask) >> (w * 32)),
          "R4 capture word", 128'(r), 128'((iv & mask) >> (w * 32)));
    end
    if (meddle) begin
      rd(4'd0, r);
      chk(r == tv[31:0], "R6 buffer write ignored", 128'(r), 128'(tv[31:0]));
      rd(4'd12, r);
      chk(r == 32'(len - 1), "R6 length write ignored", 128'(r), 128'(len - 1));
    end
  endtask

  task automatic testReset;
    logic [31:0] r;
    chk(jtagTck == 1'b0 && jtagTms == 1'b1 && jtagTdo == 1'b0 && irq == 1'b0,
        "R1 reset pins", 128'({jtagTck, jtagTms, jtagTdo, irq}), 128'(4'b0100));
    for (int a = 0; a < 15; a++) begin
      rd(4'(a), r);
      chk(r == 32'd0, "R1 reset register", 128'(r), 128'd0);
    end
  endtask

  task automatic testRegs;
    logic [31:0] r;
    wr(4'd0, 32'hDEAD_BEEF); rd(4'd0, r);
    chk(r == 32'hDEAD_BEEF, "R8 tms word readback", 128'(r), 128'hDEAD_BEEF);
    wr(4'd7, 32'h1234_5678); rd(4'd7, r);
    chk(r == 32'h1234_5678, "R8 data word readback", 128'(r), 128'h1234_5678);
    wr(4'd12, 32'hFFFF_FFFF); rd(4'd12, r);
    chk(r == 32'h7F, "R8 length width", 128'(r), 128'h7F);
    wr(4'd13, 32'hABCD_1234); rd(4'd13, r);
    chk(r == 32'h1234, "R8 divider width", 128'(r), 128'h1234);
    wr(4'd9, 32'hFFFF_FFFF); rd(4'd9, r);
    chk(r == 32'd0, "R8 capture not writable", 128'(r), 128'd0);
    rd(4'd15, r);
    chk(r == 32'd0, "R8 unmapped reads 0", 128'(r), 128'd0);
  endtask

  task automatic testAck;
    logic [31:0] r;
    wr(4'd14, 32'h2);
    chk(irq == 1'b0, "R7 ack clears irq", 128'(irq), 128'd0);
    rd(4'd14, r);
    chk(r == 32'd0, "R7 status after ack", 128'(r), 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testRegs();
    runBurst(128, 0, {32'hA5C3_0F96, 32'h0123_4567, 32'hF0F0_1E2D, 32'h8BAD_F00D},
             {32'h5A5A_C3C3, 32'hFEDC_BA98, 32'h7777_0001, 32'hCAFE_BABE},
             {32'h9E37_79B9, 32'h3C6E_F372, 32'hDEAD_10CC, 32'hB504_F333}, 1'b0);
    runBurst(1, 3, {124'd0, 4'b0001}, {124'd0, 4'b0001}, {124'd0, 4'b0001}, 1'b0);
    runBurst(37, 2, {4{32'h6B8B_4567}}, {4{32'h327B_23C6}}, {4{32'hFFFF_FFFF}}, 1'b0);
    testAck();
    runBurst(10, 20, {4{32'h0000_03A5}}, {4{32'h0000_015C}}, {4{32'h0000_02F1}}, 1'b1);
    testAck();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule